// File: doc/BRIEF.md
# Programmable Modulus Phase Accumulator

This block is the phase engine of a direct digital synthesizer. Its phase accumulator is 32 bits wide, but its modulus can be set to B × 2^32 instead of being fixed at 2^32. Each step adds a frequency tuning word to the phase. Beside it, a 32-bit fractional accumulator adds a numerator A on each step and wraps at a programmable denominator B. Every wrap puts one extra LSB into the phase in the same step. The output frequency is therefore fs × (FTW + A/B) / 2^32, so ratios such as exactly 3/10 of the clock become possible.

Software writes the tuning word, the denominator and the numerator through a small write port into staging registers. A single update strobe then copies all three into the working set, so the accumulators never run on a half-written configuration. A three-state mode register chooses how the accumulators step. In ST_IDLE both hold. In ST_PLAIN only the phase steps, and the block is a plain 2^32 accumulator. In ST_MOD both step and the wrap carry is live. On every clock the mode register moves to the mode picked by the run enable, the modulus enable and the active denominator. Any state can reach any state. The next state is ST_IDLE when run_en is low, ST_MOD when run_en and mod_en are high and the active B is not zero, and ST_PLAIN otherwise.

Top module: `pmod_phase_acc`

## Requirements
- R1: A synchronous reset clears the phase, the fractional accumulator, all staging and active registers, and puts the mode register in ST_IDLE, so `phase` reads 0 after reset.
- R2: A write (wr_en high) to address 0x04 loads the tuning word, to 0x05 the denominator B, and to 0x06 the numerator A. These go into staging registers only and do not change how the phase steps until an update. Writes to any other address are ignored.
- R3: At a clock edge with `upd` high, all three staging values as they stood before that edge become active together. A write in the same cycle lands only in staging. The first step to use the new values is the one at the next edge.
- R4: The mode register takes its next value at each edge from run_en, mod_en and the active B: ST_IDLE if run_en is low, ST_MOD if mod_en is high and B is not zero, otherwise ST_PLAIN. A step follows the registered mode, so a change of run_en first affects the phase one edge later.
- R5: In ST_IDLE, both the phase and the fractional accumulator hold their values.
- R6: In ST_PLAIN, the phase advances by the active tuning word modulo 2^32 on each clock. No extra LSB is added, and the fractional accumulator holds.
- R7: In ST_MOD, the fractional accumulator adds A. When the sum is at least B, it subtracts B and the phase gets FTW + 1 in that same step. Otherwise the phase gets FTW. A is expected to be less than B.
- R8: With tuning word 0x4CCCCCCC, A = 4 and B = 5, starting from zero, the phase is 0x80000000 after 5 modulus steps and 0 again after 10. This is exactly 3/10 of the clock rate.
- R9: With mod_en high but an active B of zero, the block behaves as ST_PLAIN and adds no carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Run enable; low parks the accumulators |
| mod_en | input | 1 | Enables the programmable modulus carry |
| wr_en | input | 1 | Write strobe for the staging registers |
| wr_addr | input | 8 | Write address (0x04 tuning word, 0x05 B, 0x06 A) |
| wr_data | input | 32 | Write data |
| upd | input | 1 | Copies all staging registers to the active set |
| phase | output | 32 | Current phase word |

## Verification
A write shows up in staging after one edge. An update makes the staging values active at its own edge, and the first phase step using them happens one edge later. A change of run_en or mod_en changes the mode at the next edge, and the phase step that follows that mode happens at the edge after. The bench drives inputs on falling edges and advances its own reference model once per rising edge, using the inputs it applied and the model state from before the edge. It then compares the phase on the next falling edge. The directed checks follow the same count: for example, after run_en rises, the first sample expects an unchanged phase, and the 5-step and 10-step values for R8 are counted from the first edge run in ST_MOD.

// File: rtl/pmpa_pkg.sv
package pmpa_pkg;
    localparam int unsigned PM_W     = 32;
    localparam int unsigned PM_AW    = 8;
    localparam int unsigned PM_BASE  = 4;
    localparam int unsigned PM_SLOTS = 3;

    // slot order follows the address order: tuning word, denominator, numerator
    localparam int unsigned SLOT_FTW = 0;
    localparam int unsigned SLOT_DEN = 1;
    localparam int unsigned SLOT_NUM = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PLAIN = 2'd1,
        ST_MOD   = 2'd2
    } pm_state_e;
endpackage

// File: rtl/pm_cfg_bank.sv
module pm_cfg_bank
    import pmpa_pkg::*;
#(
    parameter int unsigned W     = PM_W,
    parameter int unsigned AW    = PM_AW,
    parameter int unsigned BASE  = PM_BASE,
    parameter int unsigned SLOTS = PM_SLOTS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          upd,
    output logic [W-1:0]  ftw_act,
    output logic [W-1:0]  den_act,
    output logic [W-1:0]  num_act
);
    logic [W-1:0] act_vec [SLOTS];

    for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
        localparam logic [AW-1:0] SLOT_ADDR = AW'(BASE + gi);
        logic [W-1:0] stage_q;
        logic [W-1:0] live_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q <= '0;
                live_q  <= '0;
            end else begin
                if (upd) begin
                    live_q <= stage_q;
                end
                if (wr_en && (wr_addr == SLOT_ADDR)) begin
                    stage_q <= wr_data;
                end
            end
        end

        assign act_vec[gi] = live_q;
    end

    assign ftw_act = act_vec[SLOT_FTW];
    assign den_act = act_vec[SLOT_DEN];
    assign num_act = act_vec[SLOT_NUM];
endmodule

// File: rtl/pm_frac_acc.sv
module pm_frac_acc
    import pmpa_pkg::*;
#(
    parameter int unsigned W = PM_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         carry,
    output logic [W-1:0] frac
);
    localparam int unsigned SW = W + 1;

    logic [W-1:0]  frac_q;
    logic [SW-1:0] sum;
    logic [SW-1:0] wrapped;

    always_comb begin
        sum     = {1'b0, frac_q} + {1'b0, num};
        carry   = step && (sum >= {1'b0, den});
        wrapped = carry ? (sum - {1'b0, den}) : sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frac_q <= '0;
        end else if (step) begin
            frac_q <= wrapped[W-1:0];
        end
    end

    assign frac = frac_q;
endmodule

// File: rtl/pm_phase_reg.sv
module pm_phase_reg
    import pmpa_pkg::*;
#(
    parameter int unsigned W = PM_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] ftw,
    input  logic         carry,
    output logic [W-1:0] phase
);
    logic [W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (step) begin
            phase_q <= phase_q + ftw + W'(carry);
        end
    end

    assign phase = phase_q;
endmodule

// File: rtl/pmod_phase_acc.sv
module pmod_phase_acc
    import pmpa_pkg::*;
#(
    parameter int unsigned W    = PM_W,
    parameter int unsigned AW   = PM_AW,
    parameter int unsigned BASE = PM_BASE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_en,
    input  logic          mod_en,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          upd,
    output logic [W-1:0]  phase
);
    pm_state_e    state;
    pm_state_e    state_nxt;
    logic [W-1:0] ftw_act;
    logic [W-1:0] den_act;
    logic [W-1:0] num_act;
    logic [W-1:0] frac;
    logic         carry;
    logic         phase_step;
    logic         frac_step;
    logic         den_ok;

    assign den_ok = (den_act != '0);

    pm_cfg_bank #(.W(W), .AW(AW), .BASE(BASE), .SLOTS(PM_SLOTS)) i_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .upd     (upd),
        .ftw_act (ftw_act),
        .den_act (den_act),
        .num_act (num_act)
    );

    // mode register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // transition choice: every state may reach every state
    always_comb begin
        state_nxt = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_PLAIN, ST_MOD: begin
                if (!run_en) begin
                    state_nxt = ST_IDLE;
                end else if (mod_en && den_ok) begin
                    state_nxt = ST_MOD;
                end else begin
                    state_nxt = ST_PLAIN;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // per-state step controls
    always_comb begin
        phase_step = 1'b0;
        frac_step  = 1'b0;
        unique case (state)
            ST_IDLE:  begin phase_step = 1'b0; frac_step = 1'b0; end
            ST_PLAIN: begin phase_step = 1'b1; frac_step = 1'b0; end
            ST_MOD:   begin phase_step = 1'b1; frac_step = 1'b1; end
            default:  begin phase_step = 1'b0; frac_step = 1'b0; end
        endcase
    end

    pm_frac_acc #(.W(W)) i_frac (
        .clk   (clk),
        .rst   (rst),
        .step  (frac_step),
        .num   (num_act),
        .den   (den_act),
        .carry (carry),
        .frac  (frac)
    );

    pm_phase_reg #(.W(W)) i_phase (
        .clk   (clk),
        .rst   (rst),
        .step  (phase_step),
        .ftw   (ftw_act),
        .carry (carry),
        .phase (phase)
    );
endmodule

// File: rtl/pm_phase_checker.sv
module pm_phase_checker
    import pmpa_pkg::*;
#(
    parameter int unsigned W = PM_W
) (
    input logic         clk,
    input logic         rst,
    input logic         upd,
    input pm_state_e    state,
    input logic [W-1:0] phase,
    input logic [W-1:0] ftw_act,
    input logic [W-1:0] den_act,
    input logic [W-1:0] num_act,
    input logic [W-1:0] frac
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (phase == '0) && (frac == '0) && (state == ST_IDLE));

    a_r3_active_hold: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(ftw_act) && $stable(den_act) && $stable(num_act));

    a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |=> $stable(phase) && $stable(frac));

    a_r6_plain_step: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PLAIN) |=> (phase == $past(phase) + $past(ftw_act)) && $stable(frac));

    a_r7_mod_step: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MOD) |=> ((phase - $past(phase) - $past(ftw_act)) <= W'(1)));
endmodule

bind pmod_phase_acc pm_phase_checker #(.W(W)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .upd     (upd),
    .state   (state),
    .phase   (phase),
    .ftw_act (ftw_act),
    .den_act (den_act),
    .num_act (num_act),
    .frac    (frac)
);

// File: tb/test_pmod_phase_acc.sv
module test_pmod_phase_acc;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic        mod_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        upd = 1'b0;
    logic [31:0] phase;

    int checks = 0;
    int errors = 0;

    // reference model
    logic [31:0] m_stage [3];
    logic [31:0] m_act   [3];
    logic [31:0] m_phase;
    logic [31:0] m_frac;
    int          m_state; // 0 idle, 1 plain, 2 modulus

    always #(CLK_PERIOD/2) clk = ~clk;

    pmod_phase_acc i_pmod_phase_acc (
        .clk     (clk),
        .rst     (rst),
        .run_en  (run_en),
        .mod_en  (mod_en),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .upd     (upd),
        .phase   (phase)
    );

    function automatic int next_mode(logic r, logic m, logic [31:0] den);
        if (!r) return 0;
        if (m && den != 0) return 2;
        return 1;
    endfunction

    task automatic model_step();
        logic [32:0] s;
        logic        c;
        int          ns;
        if (rst) begin
            for (int i = 0; i < 3; i++) begin m_stage[i] = 0; m_act[i] = 0; end
            m_phase = 0; m_frac = 0; m_state = 0;
            return;
        end
        c = 1'b0;
        if (m_state == 2) begin
            s = {1'b0, m_frac} + {1'b0, m_act[2]};
            if (s >= {1'b0, m_act[1]}) begin c = 1'b1; s = s - {1'b0, m_act[1]}; end
            m_frac = s[31:0];
        end
        if (m_state != 0) m_phase = m_phase + m_act[0] + {31'd0, c};
        ns = next_mode(run_en, mod_en, m_act[1]);
        if (upd) for (int i = 0; i < 3; i++) m_act[i] = m_stage[i];
        if (wr_en && wr_addr >= 8'h04 && wr_addr <= 8'h06) m_stage[wr_addr - 8'h04] = wr_data;
        m_state = ns;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pulse_upd();
        upd = 1'b1;
        tick();
        upd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] p0;
        logic [31:0] p1;
        void'($urandom(32'd20240611));
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        tick();
        chk("R1 reset phase", phase, 32'h0);

        // exact 3/10 ratio
        wr(8'h04, 32'h4CCCCCCC);
        wr(8'h06, 32'd4);
        wr(8'h05, 32'd5);
        chk("R2 staged writes leave phase", phase, 32'h0);
        pulse_upd();
        run_en = 1'b1; mod_en = 1'b1;
        tick();
        chk("R4 first edge after run_en holds", phase, 32'h0);
        repeat (5) tick();
        chk("R8 five steps", phase, 32'h80000000);
        repeat (5) tick();
        chk("R8 ten steps", phase, 32'h0);
        tick();
        chk("R7 no-carry step", phase, 32'h4CCCCCCC);
        tick();
        chk("R7 carry step", phase, 32'h99999999);

        // ignored addresses and staging without update
        wr(8'h07, 32'h00000123);
        wr(8'h03, 32'h00000456);
        wr(8'h04, 32'h00000100);
        chk("R2 ignored and staged writes", phase, m_phase);

        // plain mode, update with simultaneous write
        mod_en = 1'b0;
        tick(); tick();
        p0 = phase; tick();
        chk("R6 plain step old word", phase - p0, 32'h4CCCCCCC);
        wr_en = 1'b1; wr_addr = 8'h04; wr_data = 32'h00000200; upd = 1'b1;
        tick();
        wr_en = 1'b0; upd = 1'b0;
        p0 = phase; tick();
        chk("R3 update takes pre-edge staging", phase - p0, 32'h00000100);
        pulse_upd();
        p0 = phase; tick();
        chk("R3 later update applies write", phase - p0, 32'h00000200);

        // wrap in plain mode
        wr(8'h04, 32'hFFFFFFFF);
        pulse_upd();
        p0 = phase; tick();
        chk("R6 wrap modulo 2^32", phase, p0 - 32'd1);

        // zero denominator acts as plain
        wr(8'h05, 32'd0);
        wr(8'h06, 32'd3);
        wr(8'h04, 32'd10);
        mod_en = 1'b1;
        pulse_upd();
        tick();
        p0 = phase; tick();
        chk("R9 zero denominator no carry", phase - p0, 32'd10);

        // idle hold
        run_en = 1'b0;
        tick();
        p1 = phase;
        repeat (3) tick();
        chk("R5 idle holds phase", phase, p1);
        chk("R5 model agrees", phase, m_phase);

        // constrained random
        for (int n = 0; n < 3000; n++) begin
            int st_before;
            wr_en   = ($urandom % 4) == 0;
            wr_addr = 8'(3 + ($urandom % 5));
            if (wr_addr == 8'h05 || wr_addr == 8'h06) wr_data = $urandom % 40;
            else wr_data = $urandom;
            upd    = ($urandom % 8) == 0;
            run_en = ($urandom % 8) != 0;
            mod_en = ($urandom % 4) != 0;
            st_before = m_state;
            tick();
            if (st_before == 2)      chk("R7 random modulus step", phase, m_phase);
            else if (st_before == 1) chk("R6 random plain step", phase, m_phase);
            else                     chk("R5 random idle hold", phase, m_phase);
        end
        wr_en = 1'b0; upd = 1'b0;

        // reset mid-run
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1 reset mid-run", phase, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule